// File: doc/BRIEF.md
# Parallel Port Address/Data Cycle Host Controller

This block runs the host side of an enhanced parallel port. It takes one transfer request at a time from the CPU side. A request is an address write, an address read, a data write or a data read. The block then runs the handshake on the port pins: an active-low write line, separate active-low strobes for address and data, an 8-bit bus split into output, input and output-enable, and an active-low wait input from the peripheral. When a transfer finishes, the block reports either completion (with read data for reads) or an abort.

A transfer begins only when the block is idle and the peripheral shows it is ready, which it does by holding wait low. The chosen strobe stays low until the peripheral raises wait. If wait stays low too long, a programmable timeout ends the cycle and sets a sticky flag. A port-direction control bit, when high, blocks reads. Standard-port control may force the write line at any time. The block also passes the peripheral interrupt through with a rising-edge pulse, and drives the active-low peripheral reset.

Top module: `epp_host`

## Requirements
- R1: Request code `req_op` bit 1 selects the strobe: 0 uses the address strobe `n_astb_o`, 1 uses the data strobe `n_dstb_o`. The two strobes are never low at the same time.
- R2: Request code bit 0 selects the direction: 0 is a write and holds `n_write_o` low for the cycle, 1 is a read and leaves it high. `n_write_o` is high when idle.
- R3: A request is taken only while idle with `n_wait_i` low (shown by `req_ready`). The strobe goes low two clocks after acceptance. It stays low until `n_wait_i` is sampled high and goes high on the next clock.
- R4: On a read, `bus_i` is captured at the clock edge where `n_wait_i` is seen high. It appears on `rd_data` while `cyc_done` pulses for one cycle.
- R5: On a write, `bus_oe` rises one clock before the strobe, stays high while the strobe is low, and `bus_o` carries the request data. `bus_oe` stays low for reads and when idle.
- R6: A read request while `spp_dir` is high is refused. `refused` pulses one cycle after the request, no strobe is driven and no completion is reported. Writes still run with `spp_dir` high.
- R7: If the strobe has been low for max(`tmo_limit`,1) clocks without `n_wait_i` going high, it is released and `cyc_abort` pulses. `tmo_flag` is set and stays set until `tmo_clear`.
- R8: While `spp_wr_ovr` is high, `n_write_o` equals `spp_wr_lvl`, also during a cycle. The strobes and the bus are unaffected.
- R9: `intr_o` follows `intr_i` without inversion. `irq_pulse` is high for one clock after each rising edge of `intr_i`.
- R10: `n_periph_rst_o` is low exactly while `periph_rst_req` is high.
- R11: During synchronous reset both strobes and `n_write_o` are high, and `bus_oe`, `cyc_done`, `cyc_abort`, `refused` and `tmo_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request |
| req_op | input | 2 | Bit 1: 0 address / 1 data; bit 0: 0 write / 1 read |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Idle and peripheral ready |
| cyc_done | output | 1 | Cycle completed pulse |
| cyc_abort | output | 1 | Cycle timed out pulse |
| rd_data | output | 8 | Captured read data |
| refused | output | 1 | Read refused pulse |
| tmo_limit | input | TW | Timeout length in clocks |
| tmo_clear | input | 1 | Clears the timeout flag |
| tmo_flag | output | 1 | Sticky timeout status |
| spp_dir | input | 1 | Port-direction control bit |
| spp_wr_ovr | input | 1 | Write line override enable |
| spp_wr_lvl | input | 1 | Override level for the write line |
| periph_rst_req | input | 1 | Peripheral reset request |
| n_write_o | output | 1 | Active-low write line |
| n_astb_o | output | 1 | Active-low address strobe |
| n_dstb_o | output | 1 | Active-low data strobe |
| bus_o | output | 8 | Bus output value |
| bus_i | input | 8 | Bus input value |
| bus_oe | output | 1 | Bus output enable |
| n_wait_i | input | 1 | Active-low wait from peripheral |
| intr_i | input | 1 | Peripheral interrupt |
| intr_o | output | 1 | Interrupt pass-through |
| irq_pulse | output | 1 | Rising-edge interrupt pulse |
| n_periph_rst_o | output | 1 | Active-low peripheral reset |

## Verification
Some rules hold on every clock, and the bound checker watches them continuously: the strobes never overlap, the bus enable leads any write strobe, a strobe drops one clock after wait is seen high, a refused read drives no pins, the timeout flag stays set until cleared, the write line goes low under a write strobe, and each interrupt edge produces a pulse. The bench scenarios cover what needs a whole transaction. They check that the strobe matches the request code, that read data arrives with completion, that write data is on the bus, and that the strobe length at timeout equals the limit, with a zero limit treated as one. They also check that requests wait while the peripheral is busy and that the override changes the write line in the middle of a cycle.

// File: rtl/epp_pkg.sv
package epp_pkg;

    localparam int EPP_DW = 8;

    // bit1: 0 = address strobe, 1 = data strobe; bit0: 0 = write, 1 = read
    typedef enum logic [1:0] {
        OP_AWR = 2'b00,
        OP_ARD = 2'b01,
        OP_DWR = 2'b10,
        OP_DRD = 2'b11
    } epp_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_STRB  = 2'd2,
        ST_END   = 2'd3
    } epp_st_e;

    typedef struct packed {
        epp_op_e                op;
        logic [EPP_DW-1:0]      wdata;
    } epp_req_t;

    function automatic logic op_is_read(epp_op_e op);
        return op[0];
    endfunction

    function automatic logic op_is_data(epp_op_e op);
        return op[1];
    endfunction

endpackage

// File: rtl/epp_tmo.sv
module epp_tmo #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    logic [TW-1:0] cnt;
    logic [TW:0]   nxt;

    assign nxt    = {1'b0, cnt} + (TW+1)'(1);
    assign expire = run && (nxt >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (!expire) begin
            cnt <= cnt + TW'(1);
        end
    end
endmodule

// File: rtl/epp_edge.sv
module epp_edge (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic rise
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sig_q <= 1'b0;
            rise  <= 1'b0;
        end else begin
            sig_q <= sig;
            rise  <= sig & ~sig_q;
        end
    end
endmodule

// File: rtl/epp_seq.sv
module epp_seq
    import epp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  epp_req_t          req,
    input  logic              dir_hi,
    input  logic              n_wait,
    input  logic [EPP_DW-1:0] bus_in,
    input  logic              expire,
    output epp_st_e           st,
    output epp_req_t          cur,
    output logic [EPP_DW-1:0] rdata,
    output logic              aborted,
    output logic              refused
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cur     <= '0;
            rdata   <= '0;
            aborted <= 1'b0;
            refused <= 1'b0;
        end else begin
            refused <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (req_valid && !n_wait) begin
                        if (op_is_read(req.op) && dir_hi) begin
                            refused <= 1'b1;
                        end else begin
                            cur     <= req;
                            aborted <= 1'b0;
                            st      <= ST_SETUP;
                        end
                    end
                end
                ST_SETUP: st <= ST_STRB;
                ST_STRB: begin
                    if (n_wait) begin
                        if (op_is_read(cur.op)) rdata <= bus_in;
                        st <= ST_END;
                    end else if (expire) begin
                        aborted <= 1'b1;
                        st      <= ST_END;
                    end
                end
                ST_END: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/epp_host.sv
module epp_host
    import epp_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [EPP_DW-1:0] req_wdata,
    output logic              req_ready,
    output logic              cyc_done,
    output logic              cyc_abort,
    output logic [EPP_DW-1:0] rd_data,
    output logic              refused,
    input  logic [TW-1:0]     tmo_limit,
    input  logic              tmo_clear,
    output logic              tmo_flag,
    input  logic              spp_dir,
    input  logic              spp_wr_ovr,
    input  logic              spp_wr_lvl,
    input  logic              periph_rst_req,
    output logic              n_write_o,
    output logic              n_astb_o,
    output logic              n_dstb_o,
    output logic [EPP_DW-1:0] bus_o,
    input  logic [EPP_DW-1:0] bus_i,
    output logic              bus_oe,
    input  logic              n_wait_i,
    input  logic              intr_i,
    output logic              intr_o,
    output logic              irq_pulse,
    output logic              n_periph_rst_o
);
    epp_st_e  st;
    epp_req_t cur;
    epp_req_t req;
    logic     aborted;
    logic     expire;
    logic     strb_on;
    logic     busy;
    logic     wr_cyc;
    logic     flag_q;

    assign req.op    = epp_op_e'(req_op);
    assign req.wdata = req_wdata;

    epp_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req      (req),
        .dir_hi   (spp_dir),
        .n_wait   (n_wait_i),
        .bus_in   (bus_i),
        .expire   (expire),
        .st       (st),
        .cur      (cur),
        .rdata    (rd_data),
        .aborted  (aborted),
        .refused  (refused)
    );

    epp_tmo #(.TW(TW)) u_tmo (
        .clk   (clk),
        .rst   (rst),
        .run   (strb_on),
        .limit (tmo_limit),
        .expire(expire)
    );

    epp_edge u_edge (
        .clk (clk),
        .rst (rst),
        .sig (intr_i),
        .rise(irq_pulse)
    );

    assign strb_on = (st == ST_STRB);
    assign busy    = (st != ST_IDLE);
    assign wr_cyc  = busy && !op_is_read(cur.op);

    assign req_ready = (st == ST_IDLE) && !n_wait_i;
    assign cyc_done  = (st == ST_END) && !aborted;
    assign cyc_abort = (st == ST_END) && aborted;

    assign n_astb_o  = !(strb_on && !op_is_data(cur.op));
    assign n_dstb_o  = !(strb_on &&  op_is_data(cur.op));
    assign n_write_o = spp_wr_ovr ? spp_wr_lvl : !wr_cyc;
    assign bus_oe    = wr_cyc && (st == ST_SETUP || st == ST_STRB);
    assign bus_o     = cur.wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (strb_on && !n_wait_i && expire) begin
            flag_q <= 1'b1;
        end else if (tmo_clear) begin
            flag_q <= 1'b0;
        end
    end
    assign tmo_flag = flag_q;

    assign intr_o         = intr_i;
    assign n_periph_rst_o = !periph_rst_req;
endmodule

// File: rtl/epp_host_chk.sv
module epp_host_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [1:0] req_op,
    input logic       req_ready,
    input logic       refused,
    input logic       cyc_abort,
    input logic       tmo_flag,
    input logic       tmo_clear,
    input logic       spp_dir,
    input logic       spp_wr_ovr,
    input logic       n_write_o,
    input logic       n_astb_o,
    input logic       n_dstb_o,
    input logic       bus_oe,
    input logic       n_wait_i,
    input logic       intr_i,
    input logic       irq_pulse
);
    // R1
    strb_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!n_astb_o && !n_dstb_o));

    // R2
    wr_line_chk: assert property (@(posedge clk) disable iff (rst)
        ((!n_astb_o || !n_dstb_o) && bus_oe && !spp_wr_ovr) |-> !n_write_o);

    // R3
    strb_release_chk: assert property (@(posedge clk) disable iff (rst)
        ((!n_astb_o || !n_dstb_o) && n_wait_i) |=> (n_astb_o && n_dstb_o));

    // R5
    oe_lead_chk: assert property (@(posedge clk) disable iff (rst)
        ((!n_astb_o || !n_dstb_o) && bus_oe) |-> $past(bus_oe));

    // R6
    read_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (req_ready && req_valid && req_op[0] && spp_dir)
        |=> (refused && n_astb_o && n_dstb_o && !bus_oe));

    // R7
    tmo_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (tmo_flag && !tmo_clear) |=> tmo_flag);

    // R7
    abort_flag_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_abort |-> tmo_flag);

    // R9
    irq_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(intr_i) |=> irq_pulse);
endmodule

bind epp_host epp_host_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_ready (req_ready),
    .refused   (refused),
    .cyc_abort (cyc_abort),
    .tmo_flag  (tmo_flag),
    .tmo_clear (tmo_clear),
    .spp_dir   (spp_dir),
    .spp_wr_ovr(spp_wr_ovr),
    .n_write_o (n_write_o),
    .n_astb_o  (n_astb_o),
    .n_dstb_o  (n_dstb_o),
    .bus_oe    (bus_oe),
    .n_wait_i  (n_wait_i),
    .intr_i    (intr_i),
    .irq_pulse (irq_pulse)
);

// File: tb/epp_host_test.sv
`timescale 1ns/1ps
module epp_host_test;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [7:0]    req_wdata = 8'h00;
    logic          req_ready, cyc_done, cyc_abort, refused, tmo_flag;
    logic [7:0]    rd_data, bus_o;
    logic [TW-1:0] tmo_limit = 8'd20;
    logic          tmo_clear = 1'b0;
    logic          spp_dir = 1'b0, spp_wr_ovr = 1'b0, spp_wr_lvl = 1'b0;
    logic          periph_rst_req = 1'b0;
    logic          n_write_o, n_astb_o, n_dstb_o, bus_oe;
    logic [7:0]    bus_i = 8'h00;
    logic          n_wait_i = 1'b0;
    logic          intr_i = 1'b0;
    logic          intr_o, irq_pulse, n_periph_rst_o;

    always #2.5 clk = ~clk;

    epp_host #(.TW(TW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_wdata(req_wdata), .req_ready(req_ready), .cyc_done(cyc_done),
        .cyc_abort(cyc_abort), .rd_data(rd_data), .refused(refused),
        .tmo_limit(tmo_limit), .tmo_clear(tmo_clear), .tmo_flag(tmo_flag),
        .spp_dir(spp_dir), .spp_wr_ovr(spp_wr_ovr), .spp_wr_lvl(spp_wr_lvl),
        .periph_rst_req(periph_rst_req), .n_write_o(n_write_o),
        .n_astb_o(n_astb_o), .n_dstb_o(n_dstb_o), .bus_o(bus_o), .bus_i(bus_i),
        .bus_oe(bus_oe), .n_wait_i(n_wait_i), .intr_i(intr_i), .intr_o(intr_o),
        .irq_pulse(irq_pulse), .n_periph_rst_o(n_periph_rst_o)
    );

    typedef struct {
        logic [1:0] op;
        logic [7:0] data;
        bit         abort;
        bit         nw;
        int         len;
    } exp_t;

    exp_t sbq[$];
    int   n_run = 0;
    int   n_fail = 0;
    bit   ended = 0;

    task automatic chk(bit ok, string tag, int act, int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // peripheral model: drives wait and read data at falling edges
    bit resp_en = 1;
    bit busy_hold = 0;
    int resp_lat = 1;
    int lowcnt = 0;
    always @(negedge clk) begin
        if (!n_astb_o || !n_dstb_o) begin
            lowcnt++;
            if (resp_en && lowcnt >= resp_lat) n_wait_i = 1'b1;
        end else begin
            lowcnt = 0;
            n_wait_i = busy_hold;
        end
    end

    // monitor: collects pin activity and scores each finished cycle
    bit         saw_a = 0, saw_d = 0, prev_low = 0, prev_oe = 0;
    bit         oe_pre = 0, oe_seen = 0, nw_seen = 1;
    logic [7:0] wd_seen = 8'h00;
    int         lowlen = 0;
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (!n_astb_o || !n_dstb_o) begin
                if (!prev_low) oe_pre = prev_oe;
                if (!n_astb_o) saw_a = 1;
                if (!n_dstb_o) saw_d = 1;
                nw_seen = n_write_o;
                oe_seen = bus_oe;
                wd_seen = bus_o;
                lowlen++;
                prev_low = 1;
            end else begin
                prev_low = 0;
            end
            prev_oe = bus_oe;
            if (cyc_done || cyc_abort) begin
                if (sbq.size() == 0) begin
                    chk(0, "R6 unexpected cycle end", 1, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(cyc_abort == e.abort, "R7 abort status", cyc_abort, e.abort);
                    chk(saw_a == !e.op[1] && saw_d == e.op[1], "R1 strobe select",
                        {saw_a, saw_d}, {!e.op[1], e.op[1]});
                    chk(nw_seen == e.nw, "R2 R8 write line", nw_seen, e.nw);
                    if (!e.op[0]) begin
                        chk(oe_pre && oe_seen, "R5 oe leads strobe", {oe_pre, oe_seen}, 3);
                        chk(wd_seen == e.data, "R5 write data", wd_seen, e.data);
                    end else begin
                        chk(!oe_seen, "R5 oe off for read", oe_seen, 0);
                        if (!e.abort) chk(rd_data == e.data, "R4 read data", rd_data, e.data);
                    end
                    if (e.abort) chk(lowlen == e.len, "R7 strobe length", lowlen, e.len);
                end
                saw_a = 0; saw_d = 0; oe_pre = 0; oe_seen = 0; lowlen = 0;
            end
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic run_cycle(logic [1:0] op, logic [7:0] d, bit abort, bit nw, int len);
        exp_t e;
        do step(); while (!req_ready);
        e.op = op; e.data = op[0] ? bus_i : d; e.abort = abort; e.nw = nw; e.len = len;
        sbq.push_back(e);
        req_op = op; req_wdata = d; req_valid = 1'b1;
        step();
        req_valid = 1'b0;
        while (sbq.size() != 0) step();
        step(); step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "R3 watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        step();
        // R11 reset state
        chk(n_astb_o && n_dstb_o && n_write_o, "R11 strobes and write high", {n_astb_o, n_dstb_o, n_write_o}, 7);
        chk(!bus_oe && !cyc_done && !cyc_abort && !refused && !tmo_flag, "R11 status low",
            {bus_oe, cyc_done, cyc_abort, refused, tmo_flag}, 0);
        rst = 1'b0;
        step();

        // R1 R2 R4 R5 four request kinds, varied latency
        resp_lat = 1; run_cycle(2'b00, 8'hA5, 0, 0, 0);
        bus_i = 8'h3C; run_cycle(2'b01, 8'h00, 0, 1, 0);
        resp_lat = 3; run_cycle(2'b10, 8'h5A, 0, 0, 0);
        bus_i = 8'hC3; run_cycle(2'b11, 8'h00, 0, 1, 0);
        resp_lat = 2; run_cycle(2'b10, 8'hFF, 0, 0, 0);

        // R3 no start while peripheral busy
        busy_hold = 1;
        step(); step();
        chk(!req_ready, "R3 not ready while wait high", req_ready, 0);
        req_op = 2'b10; req_wdata = 8'h11; req_valid = 1'b1;
        begin
            bit quiet = 1;
            for (int i = 0; i < 5; i++) begin
                step();
                if (!n_astb_o || !n_dstb_o || bus_oe || cyc_done) quiet = 0;
            end
            chk(quiet, "R3 request held off while busy", quiet, 1);
        end
        begin
            exp_t e;
            e.op = 2'b10; e.data = 8'h11; e.abort = 0; e.nw = 0; e.len = 0;
            sbq.push_back(e);
        end
        busy_hold = 0;
        step(); step();
        req_valid = 1'b0;
        while (sbq.size() != 0) step();
        step();

        // R6 refused read with direction bit high
        spp_dir = 1'b1;
        step();
        req_op = 2'b11; req_valid = 1'b1;
        step();
        req_valid = 1'b0;
        chk(refused == 1'b1, "R6 refused pulse", refused, 1);
        chk(n_astb_o && n_dstb_o && !bus_oe, "R6 no strobe on refused read", {n_astb_o, n_dstb_o, bus_oe}, 6);
        step();
        chk(refused == 1'b0, "R6 refused is one cycle", refused, 0);
        chk(req_ready == 1'b1, "R6 block stays idle", req_ready, 1);
        run_cycle(2'b00, 8'h77, 0, 0, 0); // R6 write allowed with dir high
        spp_dir = 1'b0;

        // R7 timeout
        resp_en = 0; tmo_limit = 8'd3;
        run_cycle(2'b10, 8'h42, 1, 0, 3);
        chk(tmo_flag == 1'b1, "R7 flag set", tmo_flag, 1);
        step(); step();
        chk(tmo_flag == 1'b1, "R7 flag sticky", tmo_flag, 1);
        tmo_clear = 1'b1; step(); tmo_clear = 1'b0; step();
        chk(tmo_flag == 1'b0, "R7 flag cleared", tmo_flag, 0);
        tmo_limit = 8'd0;
        run_cycle(2'b01, 8'h00, 1, 1, 1);
        tmo_clear = 1'b1; step(); tmo_clear = 1'b0;
        resp_en = 1; tmo_limit = 8'd20;

        // R8 override of the write line
        spp_wr_ovr = 1'b1; spp_wr_lvl = 1'b0; step();
        chk(n_write_o == 1'b0, "R8 override low when idle", n_write_o, 0);
        spp_wr_lvl = 1'b1; step();
        chk(n_write_o == 1'b1, "R8 override high when idle", n_write_o, 1);
        run_cycle(2'b10, 8'h99, 0, 1, 0);
        spp_wr_ovr = 1'b0; step();
        chk(n_write_o == 1'b1, "R8 idle level restored", n_write_o, 1);

        // R9 interrupt
        intr_i = 1'b1; #0.5;
        chk(intr_o == 1'b1, "R9 pass-through", intr_o, 1);
        step();
        chk(irq_pulse == 1'b1, "R9 edge pulse", irq_pulse, 1);
        step();
        chk(irq_pulse == 1'b0, "R9 pulse one cycle", irq_pulse, 0);
        step();
        chk(irq_pulse == 1'b0, "R9 no pulse while held", irq_pulse, 0);
        intr_i = 1'b0; #0.5;
        chk(intr_o == 1'b0, "R9 pass-through low", intr_o, 0);

        // R10 peripheral reset
        periph_rst_req = 1'b1; #0.5;
        chk(n_periph_rst_o == 1'b0, "R10 reset asserted", n_periph_rst_o, 0);
        periph_rst_req = 1'b0; #0.5;
        chk(n_periph_rst_o == 1'b1, "R10 reset released", n_periph_rst_o, 1);

        step(); step();
        chk(sbq.size() == 0, "R3 all cycles finished", sbq.size(), 0);
        finish_run();
    end
endmodule